// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns a two-wire I2C bus to a known idle state. It is meant for power-up, or for after a fault, when a slave device may have been cut off partway through a read and is still pulling the data line low. The sequencer pulls SCL low first and lets SDA float. It then clocks SCL with SDA released and looks at SDA near the end of each high phase of SCL. Once SDA reads high, it drives a start condition and then a stop condition, which leaves every slave reset and the bus idle. If SDA stays low through a fixed number of clock attempts, it gives up and reports a timeout.

Both bus lines are open-drain. An asserted enable output pulls its line low. A released enable lets an external pull-up take the line high. Every change on a line is held for one bus step of `STEP_CYCLES` system clocks. The default of 625 cycles gives 5 us at 125 MHz. SDA is read through a two-flop synchronizer. A one-cycle `start_i` pulse begins a run. `done_o` pulses once when the run ends. The outcome and the attempt count stay on the outputs until the next accepted start.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset both enables are released, so both lines read high. `busy_o`, `done_o`, `ok_o` and `timeout_o` are all 0.
- R2: An accepted start first pulls SCL low with SDA released, and holds that for two bus steps. The first release of SCL comes 2*STEP_CYCLES clocks after the edge that sampled `start_i`.
- R3: Each bus action lasts exactly STEP_CYCLES clocks. A high phase of SCL during a failed attempt is STEP_CYCLES clocks long.
- R4: When SDA is read high at the end of an SCL high phase, the block does three things in order. It pulls SDA low while SCL stays high (a start). It pulls SCL low, releases SCL, and then releases SDA while SCL is high (a stop). Each run that succeeds shows exactly one start and one stop on the bus. The block changes its SDA enable only while SCL is released.
- R5: On success `ok_o`=1, `timeout_o`=0, and `tries_o` is the 1-based number of the attempt in which SDA read high.
- R6: If SDA reads low in all MAX_TRIES (default 32) attempts, the block ends with `timeout_o`=1, `ok_o`=0 and `tries_o`=MAX_TRIES. In that case there is no start and no stop on the bus, and both lines are released afterwards.
- R7: `done_o` is a one-cycle pulse. On success it comes (2K+5)*STEP_CYCLES clocks after the start edge, where K is the successful attempt. On timeout it comes (2*MAX_TRIES+2)*STEP_CYCLES clocks after the start edge.
- R8: A `start_i` pulse while `busy_o`=1 has no effect: the run's timing, its outcome and the single `done_o` pulse are unchanged. Results hold after `done_o` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a recovery run (accepted only when idle) |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| ok_o | output | 1 | Last run ended with start and stop issued |
| timeout_o | output | 1 | Last run ended without SDA ever reading high |
| tries_o | output | $clog2(MAX_TRIES+1) | Attempts used by the last run |

## Verification
Every result is tied to the clock edge that samples `start_i`. SCL is first released 2 bus steps after that edge. A run that succeeds at attempt K raises `done_o` after (2K+5) steps. A timeout raises `done_o` after 66 steps, since MAX_TRIES is 32. The bench counts rising edges from the start edge and samples one time unit after each edge, so every output is read after its register has updated. In that same loop it checks the count at which SCL first rises, the length of the first high phase, and the count at which `done_o` arrives. A bus model watches the lines through the run. It counts SDA edges while SCL is high, which are the starts and stops, and it releases a slave hold after a chosen number of SCL falls.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;

    // Sequencer phases; each one lasts a single bus step.
    typedef enum logic [3:0] {
        RC_IDLE,
        RC_PRE_LO,    // SCL pulled, SDA released
        RC_PRE_REL,   // settle with SDA released before clocking
        RC_HIGH,      // SCL released, SDA read at end of step
        RC_LOW,       // SCL pulled again after a failed attempt
        RC_START,     // SDA pulled while SCL high
        RC_STOP_LO,   // SCL pulled, SDA still pulled
        RC_STOP_HI,   // SCL released, SDA still pulled
        RC_STOP_REL   // SDA released while SCL high
    } rec_state_e;

    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } line_drive_t;

    function automatic line_drive_t drive_for(rec_state_e s);
        line_drive_t d;
        d.scl_low = 1'b0;
        d.sda_low = 1'b0;
        case (s)
            RC_PRE_LO, RC_PRE_REL, RC_LOW: d.scl_low = 1'b1;
            RC_START, RC_STOP_HI:          d.sda_low = 1'b1;
            RC_STOP_LO: begin
                d.scl_low = 1'b1;
                d.sda_low = 1'b1;
            end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/bus_step_timer.sv
module bus_step_timer #(
    parameter int STEP_CYCLES = 625
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CNT_W = (STEP_CYCLES > 2) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/line_sync.sv
module line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '1;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/recover_fsm.sv
module recover_fsm
    import i2c_rcv_pkg::*;
#(
    parameter int MAX_TRIES = 32,
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             tick,
    input  logic             sda_seen,
    output logic             run,
    output line_drive_t      drive,
    output logic             done,
    output logic             ok,
    output logic             timed_out,
    output logic [TRY_W-1:0] tries
);
    localparam logic [TRY_W-1:0] LIMIT = TRY_W'(MAX_TRIES);

    rec_state_e state;

    assign run   = (state != RC_IDLE);
    assign drive = drive_for(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RC_IDLE;
            done      <= 1'b0;
            ok        <= 1'b0;
            timed_out <= 1'b0;
            tries     <= '0;
        end else begin
            done <= 1'b0;
            if (state == RC_IDLE) begin
                if (start) begin
                    state     <= RC_PRE_LO;
                    ok        <= 1'b0;
                    timed_out <= 1'b0;
                    tries     <= '0;
                end
            end else if (tick) begin
                case (state)
                    RC_PRE_LO:  state <= RC_PRE_REL;
                    RC_PRE_REL: begin
                        state <= RC_HIGH;
                        tries <= TRY_W'(1);
                    end
                    RC_HIGH:    state <= sda_seen ? RC_START : RC_LOW;
                    RC_LOW: begin
                        if (tries == LIMIT) begin
                            state     <= RC_IDLE;
                            done      <= 1'b1;
                            timed_out <= 1'b1;
                        end else begin
                            state <= RC_HIGH;
                            tries <= tries + 1'b1;
                        end
                    end
                    RC_START:    state <= RC_STOP_LO;
                    RC_STOP_LO:  state <= RC_STOP_HI;
                    RC_STOP_HI:  state <= RC_STOP_REL;
                    RC_STOP_REL: begin
                        state <= RC_IDLE;
                        done  <= 1'b1;
                        ok    <= 1'b1;
                    end
                    default:     state <= RC_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover
    import i2c_rcv_pkg::*;
#(
    parameter int STEP_CYCLES = 625,
    parameter int MAX_TRIES   = 32,
    parameter int SYNC_STAGES = 2,
    localparam int TRY_W      = $clog2(MAX_TRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ok_o,
    output logic             timeout_o,
    output logic [TRY_W-1:0] tries_o
);
    logic        run;
    logic        tick;
    logic        sda_s;
    line_drive_t drive;

    line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_i),
        .q   (sda_s)
    );

    bus_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    recover_fsm #(.MAX_TRIES(MAX_TRIES), .TRY_W(TRY_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .tick      (tick),
        .sda_seen  (sda_s),
        .run       (run),
        .drive     (drive),
        .done      (done_o),
        .ok        (ok_o),
        .timed_out (timeout_o),
        .tries     (tries_o)
    );

    assign scl_oe_o = drive.scl_low;
    assign sda_oe_o = drive.sda_low;
    assign busy_o   = run;
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
    parameter int MAX_TRIES = 32,
    parameter int TRY_W     = $clog2(MAX_TRIES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             scl_oe_o,
    input logic             sda_oe_o,
    input logic             busy_o,
    input logic             done_o,
    input logic             ok_o,
    input logic             timeout_o,
    input logic [TRY_W-1:0] tries_o
);
    // R7: done lasts a single cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7: done marks the end of a busy run
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && $past(busy_o)));

    // R4: SDA is pulled only while SCL is released (start condition)
    a_r4_sda_pull_scl_high: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> !scl_oe_o);

    // R4: SDA is let go only while SCL is released (stop condition)
    a_r4_sda_free_scl_high: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe_o) |-> !scl_oe_o);

    // R5: success and timeout never both set
    a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(ok_o && timeout_o));

    // R6: attempt count bounded by the limit
    a_r6_tries_bound: assert property (@(posedge clk) disable iff (rst)
        tries_o <= TRY_W'(MAX_TRIES));

    // R8: a run begins only from a start request
    a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ok_o      (ok_o),
    .timeout_o (timeout_o),
    .tries_o   (tries_o)
);

// File: tb/i2c_bus_recover_tb.sv
`timescale 1ns/1ps
module i2c_bus_recover_tb;
    localparam int STEP  = 4;
    localparam int LIMIT = 32;
    localparam int TW    = $clog2(LIMIT + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          scl_oe, sda_oe, busy, done, ok, tmo;
    logic [TW-1:0] tries;

    int checks = 0;
    int failures = 0;
    int falls = 0;
    int hold_k = 0;
    int starts = 0;
    int stops = 0;

    wire slave_hold = (falls < hold_k);
    wire scl_line   = !scl_oe;
    wire sda_line   = !(sda_oe || slave_hold);

    always #4 clk = ~clk;

    i2c_bus_recover #(.STEP_CYCLES(STEP), .MAX_TRIES(LIMIT)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .sda_i     (sda_line),
        .scl_oe_o  (scl_oe),
        .sda_oe_o  (sda_oe),
        .busy_o    (busy),
        .done_o    (done),
        .ok_o      (ok),
        .timeout_o (tmo),
        .tries_o   (tries)
    );

    always @(negedge scl_line) falls++;
    always @(negedge sda_line) if (scl_line) starts++;
    always @(posedge sda_line) if (scl_line) stops++;

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(scl_line == 1'b1, "R1 scl released", int'(scl_line), 1);
        chk(sda_line == 1'b1, "R1 sda released", int'(sda_line), 1);
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done low", int'({busy, done}), 0);
        chk(ok == 1'b0 && tmo == 1'b0, "R1 outcome clear", int'({ok, tmo}), 0);
    endtask

    // k: attempt at which the slave lets SDA go (>LIMIT means never)
    task automatic t_run(input int k, input bit poke);
        int n = 0;
        int n_rise = -1;
        int n_fall = -1;
        int dones = 0;
        int exp_k = (k < 1) ? 1 : k;
        bit fail = (k > LIMIT);
        int exp_n = fail ? (2 * LIMIT + 2) * STEP : (2 * exp_k + 5) * STEP;
        bit seen_low = 1'b0;
        @(negedge clk);
        falls = 0;
        hold_k = k;
        #1;
        starts = 0;
        stops = 0;
        start_i = 1'b1;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        while (n < 100 * STEP * LIMIT) begin
            @(posedge clk);
            #1;
            n++;
            if (!scl_line) seen_low = 1'b1;
            if (seen_low && scl_line && n_rise < 0) n_rise = n;
            if (n_rise >= 0 && !scl_line && n_fall < 0) n_fall = n;
            start_i = poke && (n == 10 || n == 20 || n == 3 * STEP);
            if (done) begin
                dones++;
                break;
            end
        end
        start_i = 1'b0;
        chk(n_rise == 2 * STEP, "R2 first SCL release", n_rise, 2 * STEP);
        if (exp_k >= 2)
            chk(n_fall - n_rise == STEP, "R3 high phase length", n_fall - n_rise, STEP);
        chk(n == exp_n, poke ? "R8 timing with ignored start" : "R7 done timing", n, exp_n);
        if (fail) begin
            chk(tmo == 1'b1 && ok == 1'b0, "R6 timeout flag", int'({ok, tmo}), 1);
            chk(tries == TW'(LIMIT), "R6 tries at limit", int'(tries), LIMIT);
            chk(starts == 0 && stops == 0, "R6 no start/stop", starts + stops, 0);
        end else begin
            chk(ok == 1'b1 && tmo == 1'b0, "R5 success flag", int'({ok, tmo}), 2);
            chk(int'(tries) == exp_k, "R5 tries count", int'(tries), exp_k);
            chk(starts == 1, "R4 one start", starts, 1);
            chk(stops == 1, "R4 one stop", stops, 1);
        end
        @(posedge clk);
        #1;
        if (done) dones++;
        chk(dones == 1, "R7 done single pulse", dones, 1);
        repeat (3 * STEP) begin
            @(posedge clk);
            #1;
            if (done) dones++;
        end
        chk(dones == 1 && !busy, poke ? "R8 no second run" : "R7 no extra done", dones, 1);
        chk(ok == !fail && tmo == fail, "R8 results held", int'({ok, tmo}), int'({!fail, fail}));
        if (fail)
            chk(scl_line && sda_line == !slave_hold, "R6 lines released", int'(scl_line), 1);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_run(5, 1'b0);
        t_run(0, 1'b0);
        t_run(1, 1'b0);
        t_run(2, 1'b0);
        t_run(LIMIT, 1'b0);
        t_run(LIMIT + 1, 1'b0);
        t_run(3, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule